// File: doc/BRIEF.md
# Prescaled Sample Interval Timer

This block generates a stream of single-cycle start pulses at a programmable interval, for use as the scan-start or the conversion-start strobe of a sampling front end. A fixed clock divider first turns the system clock into a base period. A prescaler then stretches this base period by a factor of 1 to 16 to form a tick, and a 16-bit divider counts ticks to close each output period. Two copies are normally instantiated side by side with different base periods. At 100 MHz, for example, a base of 5 clocks (50 ns) drives the conversion timer and a base of 10 clocks (100 ns) drives the scan timer.

The setting is 20 bits wide: prescale sits in bits 19:16 and the divider in bits 15:0. It is written as two 16-bit words, a high word and a low word, into a staging copy. The running counters take the staged setting only when the timer is started or when a period ends. A period is therefore never cut short or stretched by a write. A start/stop pair controls the timer. Converting nanoseconds into a setting is left to the software that programs the block.

Top module: `smp_interval_timer`

## Requirements
- R1: After reset, `tick_out` and `active` are 0, and the staged setting is prescale 0, divider 0.
- R2: The period in clock cycles is BASE_DIV × (prescale+1) × divider. If `start` is sampled at clock edge E, the pulses are seen after edges E+P, E+2P and so on. Each pulse lasts one cycle.
- R3: A high-word write (`wr_hi`) loads `wr_word[3:0]` as the prescale and ignores `wr_word[15:4]`. A low-word write (`wr_lo`) loads all 16 bits of `wr_word` as the divider.
- R4: A divider value of 0 counts 65536 ticks.
- R5: Staged settings reach the counters only at a start or at the edge where a period ends. A write sampled at that same edge is not part of that reload; it takes effect at the reload after it.
- R6: `stop` clears `active` at the next edge. At that edge it suppresses a pulse that was due, and it wins over a `start` sampled at the same edge.
- R7: A `start` while running restarts the period from zero with the staged setting. No pulse is issued at that edge.
- R8: `active` is 1 from the edge that samples `start` until the edge that samples `stop`. A pulse never appears while `active` is 0.
- R9: The largest prescale value, 15, stretches the base period sixteen times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_hi | input | 1 | Write strobe for the high word (prescale) |
| wr_lo | input | 1 | Write strobe for the low word (divider) |
| wr_word | input | 16 | Data for the word write |
| start | input | 1 | Start or restart pulse |
| stop | input | 1 | Stop pulse; wins over start |
| active | output | 1 | Timer running |
| tick_out | output | 1 | One-cycle pulse at the end of each period |

## Verification
A settings write can land on the very edge where a period ends and the counters reload. The bench waits until its reference model shows the next edge is terminal, then writes a new divider in that cycle. It then expects one more period at the old length and the following period at the new length. A stop can fall on the same terminal edge, or on the same edge as a start. Both cases are driven on purpose, and the bench expects no pulse and an inactive timer. Every cycle is compared against a behavioural model that counts elapsed clocks per period.

// File: rtl/smp_itv_pkg.sv
// Package: shared widths and the setting type for the interval timer.
// Assumes a 4-bit prescale and a 16-bit divider written as 16-bit words.
package smp_itv_pkg;
    localparam int PRE_W  = 4;
    localparam int DIV_W  = 16;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } itv_cfg_t;
endpackage

// File: rtl/smp_itv_stage.sv
// Staging register: holds the setting written by software as two words.
// Assumes word writes are one-cycle strobes. High-word bits above the
// prescale field are dropped.
module smp_itv_stage
    import smp_itv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [WORD_W-1:0] wr_word,
    output itv_cfg_t          staged
);
    logic unused_upper;
    assign unused_upper = ^wr_word[WORD_W-1:PRE_W];

    // Capture prescale and divider words independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged.pre <= '0;
            staged.div <= '0;
        end else begin
            if (wr_hi) staged.pre <= wr_word[PRE_W-1:0];
            if (wr_lo) staged.div <= wr_word[DIV_W-1:0];
        end
    end
endmodule

// File: rtl/smp_itv_base.sv
// Base-period strobe: one pulse every BASE_DIV clocks while running.
// Assumes restart realigns the count to the start edge.
module smp_itv_base #(
    parameter int BASE_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic base_stb
);
    localparam int BCW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

    generate
        if (BASE_DIV == 1) begin : g_direct
            logic unused_ctl;
            assign unused_ctl = restart ^ clk ^ rst_n;
            assign base_stb   = run;
        end else begin : g_count
            localparam logic [BCW-1:0] LAST = BCW'(BASE_DIV - 1);
            logic [BCW-1:0] cnt;

            // Count clocks modulo BASE_DIV from the start edge.
            always_ff @(posedge clk) begin
                if (!rst_n)       cnt <= '0;
                else if (restart) cnt <= '0;
                else if (run)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end

            assign base_stb = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/smp_itv_count.sv
// Prescale and divider counters with shadow reload at restart or terminal count.
// Assumes a divider of 0 wraps to a full 2**DIV_W ticks.
module smp_itv_count
    import smp_itv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     run,
    input  logic     base_stb,
    input  itv_cfg_t staged,
    output logic     terminal
);
    logic [PRE_W-1:0] act_pre;
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] rem;
    logic             tick;

    assign tick     = run && base_stb && (pre_cnt == act_pre);
    assign terminal = tick && (rem == '0);

    // Advance prescale and divider; reload from the staging copy at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre <= '0;
            pre_cnt <= '0;
            rem     <= '0;
        end else if (restart) begin
            act_pre <= staged.pre;
            pre_cnt <= '0;
            rem     <= staged.div - 1'b1;
        end else if (run && base_stb) begin
            if (pre_cnt == act_pre) begin
                pre_cnt <= '0;
                if (rem == '0) begin
                    act_pre <= staged.pre;
                    rem     <= staged.div - 1'b1;
                end else begin
                    rem <= rem - 1'b1;
                end
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smp_interval_timer.sv
// Top: prescaled interval timer with staged two-word setting and start/stop.
// Assumes start and stop are one-cycle strobes; stop has priority.
module smp_interval_timer
    import smp_itv_pkg::*;
#(
    parameter int BASE_DIV = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              start,
    input  logic              stop,
    output logic              active,
    output logic              tick_out
);
    itv_cfg_t staged;
    logic     restart;
    logic     base_stb;
    logic     terminal;

    assign restart = start && !stop;

    smp_itv_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_word (wr_word),
        .staged  (staged)
    );

    smp_itv_base #(.BASE_DIV(BASE_DIV)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (active),
        .base_stb (base_stb)
    );

    smp_itv_count u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (active),
        .base_stb (base_stb),
        .staged   (staged),
        .terminal (terminal)
    );

    // Run flag and registered end-of-period pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            tick_out <= 1'b0;
        end else begin
            if (stop)       active <= 1'b0;
            else if (start) active <= 1'b1;
            tick_out <= terminal && !stop && !start;
        end
    end
endmodule

// File: rtl/smp_interval_timer_chk.sv
// Checker: temporal properties of the interval timer at its ports.
// Assumes BASE_DIV is the minimum possible period in clocks.
module smp_interval_timer_chk #(
    parameter int BASE_DIV = 5
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic stop,
    input logic active,
    input logic tick_out
);
    logic [31:0] gap;

    // Clocks since the last start or pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || start)    gap <= '0;
        else if (tick_out)      gap <= 32'd1;
        else if (gap != '1)     gap <= gap + 1'b1;
    end

    p_min_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> (gap >= 32'(BASE_DIV)));

    p_stop_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!active && !tick_out));

    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> (active && !tick_out));

    p_pulse_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> active);

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !active);
endmodule

bind smp_interval_timer smp_interval_timer_chk #(.BASE_DIV(BASE_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .active   (active),
    .tick_out (tick_out)
);

// File: tb/smp_interval_timer_bench.sv
module smp_interval_timer_bench;
    localparam int BD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_hi = 1'b0, wr_lo = 1'b0, start = 1'b0, stop = 1'b0;
    logic [15:0] wr_word = '0;
    logic        active, tick_out;

    int    checks = 0, errors = 0, npulse = 0;
    string req = "R1";
    bit    armed = 1'b0, done = 1'b0;

    // reference model state
    bit     m_run = 0, m_pulse = 0;
    int     m_pre_s = 0, m_div_s = 0, m_pre_a = 0, m_div_a = 0;
    longint m_cnt = 0;

    always #5 clk = ~clk;

    smp_interval_timer #(.BASE_DIV(BD)) u_smp_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_word(wr_word),
        .start(start), .stop(stop), .active(active), .tick_out(tick_out)
    );

    function automatic longint per(int p, int d);
        return longint'(BD) * (p + 1) * ((d == 0) ? 65536 : d);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pulse = 0; m_pre_s = 0; m_div_s = 0;
            m_pre_a = 0; m_div_a = 0; m_cnt = 0;
        end else begin
            m_pulse = 0;
            if (stop) m_run = 0;
            else if (start) begin
                m_run = 1; m_pre_a = m_pre_s; m_div_a = m_div_s; m_cnt = 0;
            end else if (m_run) begin
                m_cnt++;
                if (m_cnt == per(m_pre_a, m_div_a)) begin
                    m_pulse = 1; m_cnt = 0; m_pre_a = m_pre_s; m_div_a = m_div_s;
                end
            end
            if (wr_hi) m_pre_s = int'(wr_word[3:0]);
            if (wr_lo) m_div_s = int'(wr_word);
        end
        armed = 1'b1;
    end

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (tick_out !== m_pulse || active !== m_run) begin
                errors++;
                $display("FAIL %s tick_out=%0b exp %0b active=%0b exp %0b",
                         req, tick_out, m_pulse, active, m_run);
            end
            if (tick_out) npulse++;
        end
    end

    task automatic chk(bit ok, string r, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit hi, logic [15:0] v);
        @(negedge clk); wr_hi = hi; wr_lo = !hi; wr_word = v;
        @(negedge clk); wr_hi = 0; wr_lo = 0;
    endtask

    task automatic do_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
    endtask

    task automatic gap_from_now(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_out && n < 200000);
    endtask

    task automatic wait_pre_terminal();
        do @(negedge clk); while (!(m_run && m_cnt == per(m_pre_a, m_div_a) - 1));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int g, base;
        cyc(4);
        req = "R1";
        chk(tick_out == 0 && active == 0, "R1", {tick_out, active}, 0);
        @(negedge clk) rst_n = 1;
        cyc(3);

        // R2: prescale 0, divider 3 -> 6 clocks
        req = "R2";
        wr(0, 16'd3);
        base = npulse;
        do_start();
        chk(active == 1, "R8", active, 1);
        cyc(25);
        chk(npulse - base == 4, "R2", npulse - base, 4);

        // R3 and R5: upper high-word bits ignored, new setting after current period
        req = "R3";
        wr(1, 16'hFFF2);
        wr(0, 16'd2);
        @(negedge clk);
        while (!tick_out) @(negedge clk);
        gap_from_now(g);
        chk(g == 12, "R3", g, 12);

        // R9: maximum prescale
        req = "R9";
        wr(1, 16'h000F);
        wr(0, 16'd1);
        @(negedge clk);
        while (!tick_out) @(negedge clk);
        gap_from_now(g);
        chk(g == 32, "R9", g, 32);

        // R5: write lands on the terminal edge
        req = "R5";
        wait_pre_terminal();
        wr_lo = 1; wr_word = 16'd4;
        @(negedge clk); wr_lo = 0;
        chk(tick_out == 1, "R5", tick_out, 1);
        gap_from_now(g);
        chk(g == 32, "R5", g, 32);
        gap_from_now(g);
        chk(g == 128, "R5", g, 128);

        // R7: restart mid-period
        req = "R7";
        wr(0, 16'd1);
        cyc(10);
        do_start();
        chk(tick_out == 0, "R7", tick_out, 0);
        gap_from_now(g);
        chk(g == 32, "R7", g, 32);

        // R6: stop suppresses further pulses
        req = "R6";
        do_stop();
        base = npulse;
        cyc(80);
        chk(npulse == base && active == 0, "R6", npulse - base, 0);
        // stop on the terminal edge
        do_start();
        wait_pre_terminal();
        stop = 1;
        @(negedge clk); stop = 0;
        chk(tick_out == 0 && active == 0, "R6", {tick_out, active}, 0);
        // stop and start together
        @(negedge clk); stop = 1; start = 1;
        @(negedge clk); stop = 0; start = 0;
        chk(active == 0, "R6", active, 0);

        // R4: divider zero -> 65536 ticks
        req = "R4";
        wr(1, 16'h0000);
        wr(0, 16'h0000);
        do_start();
        gap_from_now(g);
        chk(g == 2 * 65536, "R4", g, 2 * 65536);
        do_stop();
        cyc(2);
        finish_run();
    end
endmodule